// File: doc/BRIEF.md
# Multiplexed Address/Data Write Sequencer

This block runs single write cycles to an external 16-bit memory over one shared address/data bus. A request carries an address and a data word. The sequencer drives the address and pulses an address-latch strobe, so that an external latch captures the address when the strobe ends. It then releases the bus for one cycle. After that it drives the data word and holds an active-low write strobe for a programmed number of clock cycles. All timing is counted in whole clock cycles.

Four configuration inputs shape each cycle. A 5-bit duration sets the length of the data cycle. A flash-mode enable removes seven cycles from the strobe and adds seven recovery cycles after it. A hold enable keeps the data driven for one extra cycle after the strobe rises. A polarity bit selects an active-low latch strobe. All four are sampled when a request is accepted. A request is accepted only while `ready` is high. `done` pulses high for one cycle when the sequencer returns to idle.

Top module: `adw_write_seq`

## Requirements
- R1: `ad_oe` is high, with `ad_out` equal to the address, during the two strobe cycles and the single cycle after them. `ad_oe` is low during the next cycle (the float gap). `ad_oe` is high, with `ad_out` equal to the data, for every cycle in which `wr_n` is low. `ad_oe` is low in idle.
- R2: The latch strobe is active for exactly 2 consecutive cycles per write, starting in the cycle after acceptance.
- R3: `wr_n` falls exactly 2 cycles after the latch strobe goes inactive. With t=0 as the first cycle after acceptance, `wr_n` is first low at t=4.
- R4: With duration D and F = 7 (flash enabled) or F = 0 (flash disabled), `wr_n` stays low for D − F cycles whenever D > F.
- R5: When D ≤ F, which includes D = 0, `wr_n` stays low for exactly 1 cycle.
- R6: With flash mode enabled, the write strobe is followed by 7 recovery cycles with `wr_n` high and `ad_oe` low before the sequencer returns to idle.
- R7: With the hold enable set, the data stays on the bus with `ad_oe` high for 1 cycle after `wr_n` rises. Without it, `ad_oe` drops in the cycle in which `wr_n` rises.
- R8: When requests are held back-to-back, `wr_n` stays high for at least F + H + 1 cycles between one write's rising edge and the next write's falling edge, where H = 1 if the hold enable is set and 0 otherwise.
- R9: The latch strobe is active-high after reset, with idle level 0. When the polarity bit is 1 at acceptance, `ale` is inverted for that write. `ale` keeps the inverted idle level until the next accepted request.
- R10: `ready` is high only in idle, and requests made while busy are ignored. `done` is a single-cycle pulse at t = 4 + W + H + F, where W is the strobe width. `ready` is high in that same cycle.
- R11: Configuration and request inputs that change after acceptance have no effect on the write in progress.
- R12: While reset is asserted and right after it: `ready`=1, `ale`=0, `wr_n`=1, `ad_oe`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_addr | input | 16 | Address of the write |
| req_data | input | 16 | Data of the write |
| cfg_dur | input | 5 | Data-cycle duration D in cycles |
| cfg_hold_en | input | 1 | Adds one data hold cycle after the strobe |
| cfg_flash_en | input | 1 | Flash mode: F = 7 |
| cfg_ale_low | input | 1 | Selects an active-low latch strobe |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle pulse at the end of a write |
| ale | output | 1 | Address latch strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | 16 | Shared address/data bus value |
| ad_oe | output | 1 | Bus output enable |

## Verification
The bench goes after the points where the strobe width clamps: D = 0, D = F, D just below F, and the largest D. A design that subtracted without clamping would wrap to a very long strobe, or produce none at all. The bench also checks the float gap between the address and data phases. Dropping the gap would drive the bus while the latch might still be sampling, and extending it would shift every strobe edge.

The bench holds requests back to back to measure the gap between strobes. It also changes the configuration and request inputs in the middle of a write. A design that read the configuration live would change the strobe width or the polarity partway through a write. A design that accepted requests while busy would corrupt the running write. A design that kept the strobe polarity from reset would show the wrong idle level after an active-low write.

// File: rtl/adw_pkg.sv
package adw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_AHOLD,
    PH_FLOAT,
    PH_WRITE,
    PH_HOLD,
    PH_RECOV
  } phase_t;

  // Strobe low time: duration minus recovery, never below one cycle.
  function automatic int unsigned strobe_len(int unsigned dur, int unsigned recov);
    return (dur > recov) ? dur - recov : 1;
  endfunction

  function automatic int unsigned recov_len(bit flash_en, int unsigned flash_cyc);
    return flash_en ? flash_cyc : 0;
  endfunction

  function automatic int unsigned hold_len(bit hold_en, int unsigned hold_cyc);
    return hold_en ? hold_cyc : 0;
  endfunction

endpackage

// File: rtl/adw_cfg_latch.sv
module adw_cfg_latch #(
  parameter int DUR_W     = 5,
  parameter int CNT_W     = 7,
  parameter int FLASH_CYC = 7,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic             cfg_hold_en,
  input  logic             cfg_flash_en,
  input  logic             cfg_ale_low,
  output logic [CNT_W-1:0] wr_len,
  output logic [CNT_W-1:0] hold_len,
  output logic [CNT_W-1:0] recov_len,
  output logic             pol_low
);
  import adw_pkg::*;

  logic [CNT_W-1:0] wr_len_d, hold_len_d, recov_len_d;

  always_comb begin
    recov_len_d = CNT_W'(adw_pkg::recov_len(cfg_flash_en, FLASH_CYC));
    hold_len_d  = CNT_W'(adw_pkg::hold_len(cfg_hold_en, HOLD_CYC));
    wr_len_d    = CNT_W'(strobe_len(int'(cfg_dur), int'(recov_len_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_len    <= CNT_W'(1);
      hold_len  <= '0;
      recov_len <= '0;
      pol_low   <= 1'b0;
    end else if (accept) begin
      wr_len    <= wr_len_d;
      hold_len  <= hold_len_d;
      recov_len <= recov_len_d;
      pol_low   <= cfg_ale_low;
    end
  end

  AST_WR_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_len != '0); // R5

endmodule

// File: rtl/adw_phase_fsm.sv
module adw_phase_fsm #(
  parameter int CNT_W         = 7,
  parameter int ALE_CYC       = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int FLOAT_CYC     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] wr_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic [CNT_W-1:0] recov_len,
  output adw_pkg::phase_t  phase,
  output logic             ready,
  output logic             done
);
  import adw_pkg::*;

  phase_t           nxt;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             cnt_end;

  assign cnt_end = (cnt == '0);
  assign ready   = (phase == PH_IDLE);

  always_comb begin
    nxt     = phase;
    nxt_cnt = cnt - CNT_W'(1);
    unique case (phase)
      PH_IDLE: begin
        nxt_cnt = cnt;
        if (accept) begin
          nxt     = PH_ALE;
          nxt_cnt = CNT_W'(ALE_CYC - 1);
        end
      end
      PH_ALE: if (cnt_end) begin
        nxt     = PH_AHOLD;
        nxt_cnt = CNT_W'(ADDR_HOLD_CYC - 1);
      end
      PH_AHOLD: if (cnt_end) begin
        nxt     = PH_FLOAT;
        nxt_cnt = CNT_W'(FLOAT_CYC - 1);
      end
      PH_FLOAT: if (cnt_end) begin
        nxt     = PH_WRITE;
        nxt_cnt = wr_len - CNT_W'(1);
      end
      PH_WRITE: if (cnt_end) begin
        if (hold_len != '0) begin
          nxt     = PH_HOLD;
          nxt_cnt = hold_len - CNT_W'(1);
        end else if (recov_len != '0) begin
          nxt     = PH_RECOV;
          nxt_cnt = recov_len - CNT_W'(1);
        end else begin
          nxt     = PH_IDLE;
        end
      end
      PH_HOLD: if (cnt_end) begin
        if (recov_len != '0) begin
          nxt     = PH_RECOV;
          nxt_cnt = recov_len - CNT_W'(1);
        end else begin
          nxt     = PH_IDLE;
        end
      end
      PH_RECOV: if (cnt_end) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      cnt   <= nxt_cnt;
      done  <= (phase != PH_IDLE) && (nxt == PH_IDLE);
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready); // R10

endmodule

// File: rtl/adw_bus_drive.sv
module adw_bus_drive #(
  parameter int BUS_W = 16,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_data,
  input  adw_pkg::phase_t  phase,
  input  logic             pol_low,
  input  logic [CNT_W-1:0] wr_len,
  output logic             ale,
  output logic             wr_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             ale_act,
  output logic             wr_act
);
  import adw_pkg::*;

  logic [BUS_W-1:0] addr_q, data_q;
  logic             addr_phase, data_phase;
  logic [CNT_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign ale_act    = (phase == PH_ALE);
  assign wr_act     = (phase == PH_WRITE);
  assign addr_phase = (phase == PH_ALE) || (phase == PH_AHOLD);
  assign data_phase = (phase == PH_WRITE) || (phase == PH_HOLD);

  assign ale    = ale_act ^ pol_low;
  assign wr_n   = ~wr_act;
  assign ad_oe  = addr_phase | data_phase;
  assign ad_out = addr_phase ? addr_q : (data_phase ? data_q : '0);

  // Length of the current low run of the write strobe, for the width check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run <= '0;
    else if (!wr_n) low_run <= low_run + CNT_W'(1);
    else            low_run <= '0;
  end

  AST_WR_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R1
  AST_ALE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_act && $past(ale_act)) |=> !ale_act); // R2
  AST_WR_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (!$past(ale_act) && !$past(ale_act, 2) && $past(ale_act, 3))); // R3
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (low_run == wr_len)); // R4

endmodule

// File: rtl/adw_write_seq.sv
module adw_write_seq #(
  parameter int BUS_W         = 16,
  parameter int DUR_W         = 5,
  parameter int ALE_CYC       = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int FLOAT_CYC     = 1,
  parameter int FLASH_CYC     = 7,
  parameter int HOLD_CYC      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_data,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic             cfg_hold_en,
  input  logic             cfg_flash_en,
  input  logic             cfg_ale_low,
  output logic             ready,
  output logic             done,
  output logic             ale,
  output logic             wr_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe
);
  import adw_pkg::*;

  localparam int CNT_W = DUR_W + 2;

  logic             accept;
  logic [CNT_W-1:0] wr_len, hold_len, recov_len;
  logic             pol_low, ale_act, wr_act;
  phase_t           phase;

  assign accept = req_valid & ready;

  adw_cfg_latch #(
    .DUR_W(DUR_W), .CNT_W(CNT_W), .FLASH_CYC(FLASH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cfg_dur(cfg_dur), .cfg_hold_en(cfg_hold_en),
    .cfg_flash_en(cfg_flash_en), .cfg_ale_low(cfg_ale_low),
    .wr_len(wr_len), .hold_len(hold_len), .recov_len(recov_len),
    .pol_low(pol_low)
  );

  adw_phase_fsm #(
    .CNT_W(CNT_W), .ALE_CYC(ALE_CYC),
    .ADDR_HOLD_CYC(ADDR_HOLD_CYC), .FLOAT_CYC(FLOAT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .wr_len(wr_len), .hold_len(hold_len), .recov_len(recov_len),
    .phase(phase), .ready(ready), .done(done)
  );

  adw_bus_drive #(
    .BUS_W(BUS_W), .CNT_W(CNT_W)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_addr(req_addr), .req_data(req_data),
    .phase(phase), .pol_low(pol_low), .wr_len(wr_len),
    .ale(ale), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale_act(ale_act), .wr_act(wr_act)
  );

  AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!ad_oe && wr_n && !ale_act)); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && req_valid) |=> $stable(pol_low)); // R11

endmodule

// File: tb/tb_adw_write_seq.sv
module tb_adw_write_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic [4:0]  cfg_dur = '0;
  logic        cfg_hold_en = 1'b0, cfg_flash_en = 1'b0, cfg_ale_low = 1'b0;
  logic        ready, done, ale, wr_n, ad_oe;
  logic [15:0] ad_out;

  int checks = 0, fails = 0;
  bit idle_pol = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adw_write_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .cfg_dur(cfg_dur),
    .cfg_hold_en(cfg_hold_en), .cfg_flash_en(cfg_flash_en),
    .cfg_ale_low(cfg_ale_low), .ready(ready), .done(done), .ale(ale),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  // {dur[39:35], hold[34], flash[33], pol[32], addr[31:16], data[15:0]}
  localparam logic [39:0] VEC [9] = '{
    {5'd5,  1'b0, 1'b0, 1'b0, 16'h1234, 16'hABCD},
    {5'd10, 1'b1, 1'b0, 1'b0, 16'h00FF, 16'h5A5A},
    {5'd12, 1'b0, 1'b1, 1'b0, 16'hF00D, 16'h0001},
    {5'd20, 1'b1, 1'b1, 1'b1, 16'h8001, 16'hC3C3},
    {5'd0,  1'b0, 1'b0, 1'b0, 16'h7777, 16'h8888},
    {5'd7,  1'b0, 1'b1, 1'b0, 16'h0F0F, 16'hF0F0},
    {5'd3,  1'b1, 1'b1, 1'b1, 16'hCAFE, 16'hBEEF},
    {5'd31, 1'b1, 1'b0, 1'b1, 16'hFFFF, 16'h0000},
    {5'd1,  1'b0, 1'b0, 1'b0, 16'h2468, 16'h1357}
  };

  function automatic int exp_width(int d, bit f);
    if (f) return (d <= 7) ? 1 : d - 7;
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One write; mess=1 also disturbs request and config inputs while busy.
  task automatic do_write(input logic [39:0] v, input bit mess);
    int d, w, tot, f7;
    bit h, f, p;
    logic [15:0] a, dt;
    bit ale_ok = 1, wr_ok = 1, bus_ok = 1, end_ok = 1;
    int ale_a = 0, ale_e = 0, wr_a = 0, wr_e = 0, bus_a = 0, bus_e = 0, end_a = 0, end_e = 0;
    d = int'(v[39:35]); h = v[34]; f = v[33]; p = v[32];
    a = v[31:16]; dt = v[15:0];
    f7 = f ? 7 : 0;
    w = exp_width(d, f);
    tot = 4 + w + (h ? 1 : 0) + f7;
    @(negedge clk);
    chk(ready == 1'b1 && ale == idle_pol, "R9", "idle ready/ale", {ready, ale}, {1'b1, idle_pol});
    req_valid = 1'b1; req_addr = a; req_data = dt;
    cfg_dur = v[39:35]; cfg_hold_en = h; cfg_flash_en = f; cfg_ale_low = p;
    @(negedge clk);
    if (mess) begin
      req_addr = ~a; req_data = ~dt; cfg_dur = 5'd2;
      cfg_hold_en = ~h; cfg_flash_en = ~f; cfg_ale_low = ~p;
    end else begin
      req_valid = 1'b0;
    end
    for (int t = 0; t <= tot; t++) begin
      bit e_ale, e_wr, e_oe, e_end;
      logic [15:0] e_ad;
      e_ale = (t < 2) ^ p;
      e_wr  = !(t >= 4 && t < 4 + w);
      e_oe  = (t < 3) || (t >= 4 && t < 4 + w + (h ? 1 : 0));
      e_ad  = (t < 3) ? a : dt;
      e_end = (t == tot);
      if (ale_ok && ale !== e_ale) begin ale_ok = 0; ale_a = ale; ale_e = e_ale; end
      if (wr_ok && wr_n !== e_wr) begin wr_ok = 0; wr_a = t; wr_e = e_wr; end
      if (bus_ok && (ad_oe !== e_oe || (e_oe && ad_out !== e_ad))) begin
        bus_ok = 0; bus_a = {ad_oe, ad_out}; bus_e = {e_oe, e_ad};
      end
      if (end_ok && (done !== e_end || ready !== e_end)) begin
        end_ok = 0; end_a = {done, ready, 8'(t)}; end_e = {e_end, e_end, 8'(t)};
      end
      if (t == tot) req_valid = 1'b0;
      else @(negedge clk);
    end
    idle_pol = p;
    chk(ale_ok, mess ? "R2/R9 R11" : "R2/R9", "ale trace", ale_a, ale_e);
    chk(wr_ok, (d <= f7 || d == 0) ? "R5" : "R3/R4", "wr_n trace (cycle/level)", wr_a, wr_e);
    chk(bus_ok, h ? "R1/R7" : (f ? "R1/R6" : "R1"), "bus oe/value", bus_a, bus_e);
    chk(end_ok, mess ? "R10 R11" : "R10", "done/ready timing", end_a, end_e);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    #1;
    repeat (2) @(negedge clk);
    chk(ready && !ale && wr_n && !ad_oe && !done, "R12", "outputs in reset",
        {ready, ale, wr_n, ad_oe, done}, 5'b10100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !ale && wr_n && !ad_oe && !done, "R12", "outputs after reset",
        {ready, ale, wr_n, ad_oe, done}, 5'b10100);

    // table walk
    foreach (VEC[i]) do_write(VEC[i], 1'b0);

    // R10/R11: inputs disturbed while busy must not affect the write
    do_write({5'd9, 1'b1, 1'b0, 1'b1, 16'h4242, 16'h2424}, 1'b1);
    do_write({5'd8, 1'b0, 1'b1, 1'b0, 16'h1111, 16'h2222}, 1'b1);

    // R8: back-to-back writes with flash and hold, gap between strobes
    begin
      int t_rise = -1, gap = -1, falls = 0;
      bit prev = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; cfg_dur = 5'd10; cfg_hold_en = 1'b1;
      cfg_flash_en = 1'b1; cfg_ale_low = 1'b0;
      for (int t = 0; t < 200 && falls < 2; t++) begin
        @(negedge clk);
        if (!prev && wr_n) t_rise = t;
        if (prev && !wr_n) begin
          falls++;
          if (falls == 2) gap = t - t_rise;
        end
        prev = wr_n;
      end
      req_valid = 1'b0;
      chk(gap >= 9, "R8", "strobe gap cycles", gap, 9);
      for (int t = 0; t < 100 && !ready; t++) @(negedge clk);
      chk(ready == 1'b1, "R10", "idle after back-to-back", ready, 1);
      idle_pol = 1'b0;
    end

    // R12: reset mid-write returns to the idle state
    @(negedge clk);
    req_valid = 1'b1; cfg_dur = 5'd20; cfg_ale_low = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(ready && !ale && wr_n && !ad_oe && !done, "R12", "async reset mid-write",
        {ready, ale, wr_n, ad_oe, done}, 5'b10100);
    @(negedge clk);
    rst_n = 1'b1;
    idle_pol = 1'b0;
    do_write(VEC[0], 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule